// File: doc/BRIEF.md
# Byte-Wide Register Bus Interface

This block sits between an 8-bit processor-style bus and a 24-bit counting datapath. The bus offers chip select, read and write strobes (all active low) and a single control/data select line. When that line is high, a write lands in one of four 6-bit control registers, picked by the top two data bits. A read returns a status byte. When the line is low, writes and reads move one byte of a 24-bit word. Writes fill the preset word and reads drain the output latch. Both go least significant byte first and share one auto-incrementing byte pointer.

Writes that select the master control register are not stored. Each bit is instead a command. The pointer-reset, latch and master-reset commands act inside the block. The remaining commands, along with latch and master reset, leave the block as one-cycle strobes for the counter datapath, which is outside this block. The bus is synchronous: each strobe is sampled on the clock and acts once on its falling edge. Separate input and output data buses stand in for a tri-state bus.

Top module: `byte_bus_regif`

## Requirements
- R1: A write with cs_n low and cd high selects a register by din[7:6]. 00 is master control, 01 is input control, 10 is output control and 11 is quadrature control. Only din[5:0] is stored in in_ctrl, out_ctrl or quad_ctrl. A master write is never stored.
- R2: A write with cs_n low and cd low stores din into byte P of the preset, where byte 0 is bits 7:0 and P is the byte pointer. P then advances 0 to 1 to 2 and wraps back to 0.
- R3: A read with cs_n low and cd low drives byte P of the output latch on dout, with byte 0 being bits 7:0. P then advances with the same wrap. dout changes only on a read.
- R4: A read with cd high drives {3'b111, status_in} on dout and leaves the pointer unchanged.
- R5: A master write with din[0] set returns the pointer to byte 0.
- R6: A master write emits a one-cycle strobe, in the cycle after the write edge, for each set bit among the following. Bit 1 drives stb_latch, bit 2 stb_cnt_rst, bit 3 stb_load, bit 4 stb_match_clr and bit 5 stb_mreset. In the cycle after stb_latch, the output latch takes cnt_in.
- R7: Several command bits set in one master write all take effect together.
- R8: A master write with din[5] set clears in_ctrl, out_ctrl and quad_ctrl and returns the pointer to byte 0.
- R9: While cs_n is high, reads and writes change no register, no pointer and no dout.
- R10: A strobe held low for many cycles acts only once.
- R11: After synchronous reset, all registers, the preset, dout and the pointer are zero and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | High selects control/status, low selects data bytes |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, held until the next read |
| cnt_in | input | 24 | Counter value captured by the latch command |
| status_in | input | 5 | Status flags returned in the status byte |
| preset | output | 24 | Assembled preset word |
| in_ctrl | output | 6 | Input control register |
| out_ctrl | output | 6 | Output control register |
| quad_ctrl | output | 6 | Quadrature control register |
| stb_latch | output | 1 | Latch-counter command pulse |
| stb_cnt_rst | output | 1 | Counter-reset command pulse |
| stb_load | output | 1 | Load-preset command pulse |
| stb_match_clr | output | 1 | Match-toggle clear pulse |
| stb_mreset | output | 1 | Master-reset pulse |

## Verification
The bench targets pointer wrap, both on the fourth preset write and on the fourth latch read. A pointer that saturated would overwrite byte 2 or repeat it. It interleaves a status read between data reads: a design that advanced the pointer on status reads would skip a byte. It holds a write strobe low for several cycles, where a level-triggered design would advance the pointer repeatedly. It issues combined commands, where a priority encoder would drop all but one strobe. It checks that master reset returns the pointer to byte 0; a design that forgot this would return a middle byte.

// File: rtl/byte_bus_pkg.sv
package byte_bus_pkg;
    localparam int BUS_W  = 8;
    localparam int NBYTES = 3;
    localparam int STAT_W = 5;
    localparam int CTRL_W = BUS_W - 2;

    typedef enum logic [1:0] {
        SEL_MASTER = 2'b00,
        SEL_INPUT  = 2'b01,
        SEL_OUTPUT = 2'b10,
        SEL_QUAD   = 2'b11
    } ctrl_sel_e;

    // bit order matches the master write data, bit 5 first
    typedef struct packed {
        logic mreset;
        logic match_clr;
        logic load;
        logic cnt_rst;
        logic latch;
        logic ptr_rst;
    } cmd_t;

    function automatic logic [BUS_W-1:0] status_byte(input logic [STAT_W-1:0] s);
        return {{(BUS_W-STAT_W){1'b1}}, s};
    endfunction
endpackage

// File: rtl/byte_bus_edge.sv
module byte_bus_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_n,
    input  logic [N-1:0] strb_n,
    output logic [N-1:0] fire
);
    logic [N-1:0] prev_n;

    for (genvar i = 0; i < N; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) prev_n[i] <= 1'b1;
            else     prev_n[i] <= strb_n[i];
        end
        assign fire[i] = ~sel_n & ~strb_n[i] & prev_n[i];
    end
endmodule

// File: rtl/byte_bus_ctrl_regs.sv
module byte_bus_ctrl_regs
    import byte_bus_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_fire,
    input  logic          cd,
    input  logic [DW-1:0] din,
    output logic [CW-1:0] in_ctrl,
    output logic [CW-1:0] out_ctrl,
    output logic [CW-1:0] quad_ctrl,
    output cmd_t          cmd
);
    logic      ctrl_wr;
    ctrl_sel_e sel;
    cmd_t      cmd_now;

    always_comb begin
        ctrl_wr = wr_fire & cd;
        sel     = ctrl_sel_e'(din[DW-1 -: 2]);
        cmd_now = '0;
        if (ctrl_wr && sel == SEL_MASTER)
            cmd_now = cmd_t'(din[$bits(cmd_t)-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_ctrl   <= '0;
            out_ctrl  <= '0;
            quad_ctrl <= '0;
            cmd       <= '0;
        end else begin
            cmd <= cmd_now;
            if (cmd_now.mreset) begin
                in_ctrl   <= '0;
                out_ctrl  <= '0;
                quad_ctrl <= '0;
            end else if (ctrl_wr) begin
                unique case (sel)
                    SEL_INPUT:  in_ctrl   <= din[CW-1:0];
                    SEL_OUTPUT: out_ctrl  <= din[CW-1:0];
                    SEL_QUAD:   quad_ctrl <= din[CW-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/byte_bus_byte_path.sv
module byte_bus_byte_path
    import byte_bus_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int NB = NBYTES,
    parameter int SW = STAT_W,
    localparam int WW = DW * NB,
    localparam int PW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_fire,
    input  logic          rd_fire,
    input  logic          cd,
    input  logic [DW-1:0] din,
    input  cmd_t          cmd,
    input  logic [WW-1:0] cnt_in,
    input  logic [SW-1:0] status_in,
    output logic [WW-1:0] preset,
    output logic [WW-1:0] latch_word,
    output logic [DW-1:0] dout
);
    logic [NB-1:0][DW-1:0] pre_q;
    logic [NB-1:0][DW-1:0] lat_q;
    logic [PW-1:0]         ptr;
    logic [PW-1:0]         ptr_nxt;
    logic                  data_wr;
    logic                  data_rd;
    logic                  ptr_clr;

    always_comb begin
        data_wr = wr_fire & ~cd;
        data_rd = rd_fire & ~cd;
        ptr_clr = cmd.ptr_rst | cmd.mreset;
        ptr_nxt = (ptr == PW'(NB-1)) ? '0 : ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            pre_q <= '0;
            lat_q <= '0;
            dout  <= '0;
        end else begin
            if (ptr_clr)                ptr <= '0;
            else if (data_wr | data_rd) ptr <= ptr_nxt;
            if (data_wr) pre_q[ptr] <= din;
            if (cmd.latch) lat_q <= cnt_in;
            if (rd_fire) dout <= cd ? status_byte(status_in) : lat_q[ptr];
        end
    end

    assign preset     = pre_q;
    assign latch_word = lat_q;
endmodule

// File: rtl/byte_bus_regif.sv
module byte_bus_regif
    import byte_bus_pkg::*;
#(
    parameter int DW = BUS_W,
    parameter int NB = NBYTES,
    parameter int SW = STAT_W,
    localparam int WW = DW * NB,
    localparam int CW = DW - 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          cd,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic [WW-1:0] cnt_in,
    input  logic [SW-1:0] status_in,
    output logic [WW-1:0] preset,
    output logic [CW-1:0] in_ctrl,
    output logic [CW-1:0] out_ctrl,
    output logic [CW-1:0] quad_ctrl,
    output logic          stb_latch,
    output logic          stb_cnt_rst,
    output logic          stb_load,
    output logic          stb_match_clr,
    output logic          stb_mreset
);
    logic [1:0]    fire;
    logic          wr_fire;
    logic          rd_fire;
    cmd_t          cmd;
    logic [WW-1:0] latch_q;

    byte_bus_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sel_n  (cs_n),
        .strb_n ({wr_n, rd_n}),
        .fire   (fire)
    );

    // a write edge in the same cycle as a read edge wins
    assign wr_fire = fire[1];
    assign rd_fire = fire[0] & ~fire[1];

    byte_bus_ctrl_regs #(.DW(DW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_fire   (wr_fire),
        .cd        (cd),
        .din       (din),
        .in_ctrl   (in_ctrl),
        .out_ctrl  (out_ctrl),
        .quad_ctrl (quad_ctrl),
        .cmd       (cmd)
    );

    byte_bus_byte_path #(.DW(DW), .NB(NB), .SW(SW)) u_path (
        .clk        (clk),
        .rst        (rst),
        .wr_fire    (wr_fire),
        .rd_fire    (rd_fire),
        .cd         (cd),
        .din        (din),
        .cmd        (cmd),
        .cnt_in     (cnt_in),
        .status_in  (status_in),
        .preset     (preset),
        .latch_word (latch_q),
        .dout       (dout)
    );

    assign stb_latch     = cmd.latch;
    assign stb_cnt_rst   = cmd.cnt_rst;
    assign stb_load      = cmd.load;
    assign stb_match_clr = cmd.match_clr;
    assign stb_mreset    = cmd.mreset;
endmodule

// File: rtl/byte_bus_regif_chk.sv
module byte_bus_regif_chk #(
    parameter int DW = 8,
    parameter int NB = 3,
    localparam int WW = DW * NB,
    localparam int CW = DW - 2
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          rd_n,
    input logic [DW-1:0] dout,
    input logic [WW-1:0] cnt_in,
    input logic [WW-1:0] preset,
    input logic [WW-1:0] latch_q,
    input logic [CW-1:0] in_ctrl,
    input logic [CW-1:0] out_ctrl,
    input logic [CW-1:0] quad_ctrl,
    input logic          stb_latch,
    input logic          stb_cnt_rst,
    input logic          stb_load,
    input logic          stb_match_clr,
    input logic          stb_mreset
);
    logic [4:0]    stb;
    logic [WW-1:0] preset_d;
    logic [NB-1:0] byte_chg;

    assign stb = {stb_mreset, stb_match_clr, stb_load, stb_cnt_rst, stb_latch};

    always_ff @(posedge clk) preset_d <= preset;

    always_comb begin
        for (int i = 0; i < NB; i++)
            byte_chg[i] = preset[i*DW +: DW] != preset_d[i*DW +: DW];
    end

    p_strobe_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (|stb) |=> (stb == '0));

    p_latch_capture_r6: assert property (@(posedge clk) disable iff (rst)
        stb_latch |=> (latch_q == $past(cnt_in)));

    p_cs_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(in_ctrl) && $stable(out_ctrl) && $stable(quad_ctrl)
                  && $stable(preset) && $stable(dout) && (stb == '0)));

    p_dout_on_read_r3: assert property (@(posedge clk) disable iff (rst)
        rd_n |=> $stable(dout));

    p_mreset_clears_r8: assert property (@(posedge clk) disable iff (rst)
        stb_mreset |-> (in_ctrl == '0 && out_ctrl == '0 && quad_ctrl == '0));

    p_one_byte_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(byte_chg) <= 1);
endmodule

bind byte_bus_regif byte_bus_regif_chk #(.DW(DW), .NB(NB)) u_chk (.*);

// File: tb/byte_bus_regif_tb.sv
module byte_bus_regif_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic [23:0] cnt_in = '0;
    logic [4:0]  status_in = '0;
    logic [23:0] preset;
    logic [5:0]  in_ctrl, out_ctrl, quad_ctrl;
    logic        stb_latch, stb_cnt_rst, stb_load, stb_match_clr, stb_mreset;
    logic [4:0]  snap, snap2;
    int          checks = 0;
    int          errors = 0;
    logic [7:0]  exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #4 clk = ~clk;

    byte_bus_regif u_dut (.*);

    wire [4:0] stbs = {stb_mreset, stb_match_clr, stb_load, stb_cnt_rst, stb_latch};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic c, input logic [7:0] d, input logic sel_n, input int hold);
        @(negedge clk);
        cs_n = sel_n; cd = c; din = d; wr_n = 1'b0;
        @(posedge clk); #2; snap = stbs;
        repeat (hold) @(negedge clk);
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
        @(posedge clk); #2; snap2 = stbs;
    endtask

    task automatic bus_rd(input logic c, input logic sel_n, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cs_n = sel_n; cd = c; rd_n = 1'b0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        @(posedge clk); #2;
    endtask

    // monitor: compares dout one edge after each read is driven
    initial begin
        forever begin
            logic [7:0] e;
            string      t;
            wait (exp_q.size() != 0);
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            @(posedge clk); #2;
            check(t, {24'd0, dout}, {24'd0, e});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 ctrl", {14'd0, in_ctrl, out_ctrl, quad_ctrl}, 32'd0);
        check("R11 preset", {8'd0, preset}, 32'd0);
        check("R11 dout/strobes", {19'd0, dout, stbs}, 32'd0);

        // R1 control decode
        bus_wr(1, 8'h6A, 0, 0);
        bus_wr(1, 8'h95, 0, 0);
        bus_wr(1, 8'hFF, 0, 0);
        check("R1 in_ctrl", {26'd0, in_ctrl}, 32'h2A);
        check("R1 out_ctrl", {26'd0, out_ctrl}, 32'h15);
        check("R1 quad_ctrl", {26'd0, quad_ctrl}, 32'h3F);
        bus_wr(1, 8'h00, 0, 0);
        check("R1 master not stored", {14'd0, in_ctrl, out_ctrl, quad_ctrl}, {14'd0, 6'h2A, 6'h15, 6'h3F});

        // R2 preset assembly and wrap
        bus_wr(1, 8'h01, 0, 0);
        bus_wr(0, 8'h11, 0, 0);
        bus_wr(0, 8'h22, 0, 0);
        bus_wr(0, 8'h33, 0, 0);
        check("R2 preset order", {8'd0, preset}, 32'h332211);
        bus_wr(0, 8'h44, 0, 0);
        check("R2 pointer wrap", {8'd0, preset}, 32'h332244);

        // R10 held strobe acts once
        bus_wr(1, 8'h01, 0, 0);
        bus_wr(0, 8'h55, 0, 3);
        bus_wr(0, 8'h66, 0, 0);
        check("R10 held write", {8'd0, preset}, 32'h336655);

        // R9 cs high ignored
        bus_wr(0, 8'h77, 1, 0);
        check("R9 data write ignored", {8'd0, preset}, 32'h336655);
        bus_wr(1, 8'h40, 1, 0);
        check("R9 ctrl write ignored", {26'd0, in_ctrl}, 32'h2A);
        bus_wr(0, 8'h88, 0, 0);
        check("R9 pointer unmoved", {8'd0, preset}, 32'h886655);

        // R6/R7 latch plus pointer reset, R3 reads
        cnt_in = 24'hABCDEF;
        bus_wr(1, 8'h03, 0, 0);
        check("R6 latch strobe", {27'd0, snap}, 32'h01);
        check("R6 strobe one cycle", {27'd0, snap2}, 32'h00);
        cnt_in = 24'h123456;
        bus_rd(0, 0, 8'hEF, "R3 byte0");
        bus_rd(0, 0, 8'hCD, "R3 byte1");
        bus_rd(0, 0, 8'hAB, "R3 byte2");
        bus_rd(0, 0, 8'hEF, "R3 wrap");

        // R4 status read does not move pointer
        status_in = 5'b01010;
        bus_rd(1, 0, 8'hEA, "R4 status");
        bus_rd(0, 0, 8'hCD, "R4 pointer kept");

        // R9 read ignored
        bus_rd(0, 1, 8'hCD, "R9 dout held");
        bus_rd(0, 0, 8'hAB, "R9 read pointer kept");

        // R6 single strobes
        bus_wr(1, 8'h04, 0, 0);
        check("R6 cnt_rst", {27'd0, snap}, 32'h02);
        bus_wr(1, 8'h08, 0, 0);
        check("R6 load", {27'd0, snap}, 32'h04);
        bus_wr(1, 8'h10, 0, 0);
        check("R6 match_clr", {27'd0, snap}, 32'h08);

        // R7/R8 combined with master reset
        bus_rd(0, 0, 8'hEF, "R8 advance");
        bus_wr(1, 8'h3C, 0, 0);
        check("R7 combined strobes", {27'd0, snap}, 32'h1E);
        check("R7 strobes clear", {27'd0, snap2}, 32'h00);
        check("R8 ctrl cleared", {14'd0, in_ctrl, out_ctrl, quad_ctrl}, 32'd0);
        bus_rd(0, 0, 8'hEF, "R8 pointer reset");

        // R5 pointer reset command
        bus_rd(0, 0, 8'hCD, "R5 advance");
        bus_wr(1, 8'h01, 0, 0);
        check("R5 no strobe", {27'd0, snap}, 32'h00);
        bus_rd(0, 0, 8'hEF, "R5 pointer reset");

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule